// File: doc/BRIEF.md
# Oscillator Stabilization Reset Sequencer

This block brings the device out of a watchdog reset in an ordered series of reset phases. A watchdog request always starts a settings-initialization phase. When the request arrived while the system was running from the subclock with the main oscillator stopped, the block then restarts the main oscillator. It also clears a free-running timebase counter, which advances once every two main-clock cycles, and waits for a counter tap chosen in advance to rise. Only after that wait does it raise the operation-initialization reset, hold it for a fixed number of cycles and hand the device over to main run. When the main oscillator was already running, the wait is skipped.

The sequencer runs on `clk`, which stands for the main clock rate. The stopped oscillator is modelled by gating the timebase counter with the oscillator enable. The interval choice is taken from `ivl_sel_i` on the cycle the watchdog request is seen. It is kept until the next request, so software sets it up before the reset happens. The tap widths `TAP0`..`TAP3` default to 12, 14, 17 and 22. A tap width T means a wait of 2^T main-clock cycles, read from counter bit T-1. The states are named SUBRUN, INIT, OSCWAIT, OPRST and MAINRUN. Their transitions are: request-to-INIT (from any state), INIT-to-OSCWAIT, INIT-to-OPRST, OSCWAIT-to-OPRST and OPRST-to-MAINRUN.

Top module: `osc_stab_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `state_o` is 0 (SUBRUN), `init_rst_o` and `op_rst_o` are low, and in SUBRUN `osc_en_o` equals the inverse of `osc_halted_i`. `state_o` never shows a code above 4.
- R2: A high `wdt_req_i` at a rising edge puts `state_o` at 1 (INIT) after that edge, from any state. INIT lasts `INIT_LEN` cycles counted from the last request cycle. `init_rst_o` is high and `op_rst_o` is low throughout INIT.
- R3: The state after INIT is 2 (OSCWAIT) when the request was taken in SUBRUN with `osc_halted_i` high. Otherwise it is 3 (OPRST), with no wait in between.
- R4: In OSCWAIT, `osc_en_o` is high and both resets are low. In INIT, `osc_en_o` is low when the oscillator was halted at the request and high when it was not.
- R5: OSCWAIT lasts exactly 2^T + 1 cycles. T is chosen by the interval code taken with the request: 0 selects `TAP0`, 1 `TAP1`, 2 `TAP2` and 3 `TAP3`. This is 2^T counting cycles from a cleared counter plus one detect cycle.
- R6: Changes on `ivl_sel_i` after the request cycle do not change the length of the wait that follows.
- R7: OPRST (code 3) lasts `RST_LEN` cycles with `op_rst_o` high and `init_rst_o` low. It is followed by MAINRUN (code 4), where both resets are low and `osc_en_o` is high. MAINRUN persists until the next request.
- R8: A request during OSCWAIT or OPRST restarts the sequence at INIT. If it came during OSCWAIT, a full-length wait follows again. If it came during OPRST or MAINRUN, the wait is skipped whatever the level of `osc_halted_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock at the main clock rate |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_req_i | input | 1 | Watchdog reset request |
| osc_halted_i | input | 1 | Main oscillator is stopped by software |
| ivl_sel_i | input | 2 | Stabilization interval code |
| osc_en_o | output | 1 | Main oscillator enable |
| init_rst_o | output | 1 | Settings-initialization reset |
| op_rst_o | output | 1 | Operation-initialization reset |
| state_o | output | 3 | Encoded sequencer state |

## Verification
Directed requests are issued from SUBRUN with the oscillator halted, once for each of the four interval codes. Each distinct wait length shows that the right tap is chosen, and the one extra cycle shows where the counter is cleared. A request with the oscillator running tells the wait-skip path apart from the wait path. A request from MAINRUN with the halt input still high shows that the halt level only counts in SUBRUN. Changing the interval code right after the request separates capture-at-request from live use. Requests placed in the middle of the wait and in the middle of the operation reset show that the restart rebuilds the full wait in one case and skips it in the other.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;

    typedef enum logic [2:0] {
        ST_SUBRUN  = 3'd0,
        ST_INIT    = 3'd1,
        ST_OSCWAIT = 3'd2,
        ST_OPRST   = 3'd3,
        ST_MAINRUN = 3'd4
    } seq_state_e;

    localparam int unsigned SEL_W  = 2;
    localparam int unsigned N_TAPS = 1 << SEL_W;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/osc_stab_timebase.sv
// Timebase counter advancing at half the main clock rate; one tap per interval code.
module osc_stab_timebase
    import osc_stab_pkg::*;
#(
    parameter int unsigned TAP0 = 12,
    parameter int unsigned TAP1 = 14,
    parameter int unsigned TAP2 = 17,
    parameter int unsigned TAP3 = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);

    localparam int unsigned CW = max2(max2(TAP0, TAP1), max2(TAP2, TAP3));

    logic              half_q;
    logic [CW-1:0]     cnt_q;
    logic [N_TAPS-1:0] tap_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else if (clear_i) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else if (run_i) begin
            half_q <= ~half_q;
            if (half_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // A wait of 2^T main cycles is 2^(T-1) counts, seen on bit T-1.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned TW = (g == 0) ? TAP0 :
                                     (g == 1) ? TAP1 :
                                     (g == 2) ? TAP2 : TAP3;
        assign tap_bits[g] = cnt_q[TW-1];
    end

    assign hit_o = tap_bits[sel_i];

endmodule

// File: rtl/osc_stab_dwell.sv
// Saturating phase-length counter, cleared whenever the sequencer changes phase.
module osc_stab_dwell #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (cnt_o != {W{1'b1}}) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/osc_stab_fsm.sv
// Reset phase controller: state register, next-state logic, request capture and output decode.
module osc_stab_fsm
    import osc_stab_pkg::*;
#(
    parameter int unsigned INIT_LEN = 4,
    parameter int unsigned RST_LEN  = 16,
    parameter int unsigned DW       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_req_i,
    input  logic             osc_halted_i,
    input  logic [SEL_W-1:0] ivl_sel_i,
    input  logic             tap_hit_i,
    input  logic [DW-1:0]    dwell_i,
    output seq_state_e       state_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             tb_clear_o,
    output logic             dwell_clear_o,
    output logic             osc_en_o,
    output logic             init_rst_o,
    output logic             op_rst_o
);

    seq_state_e       state_q, state_d;
    logic             halt_q, halt_at_req;
    logic [SEL_W-1:0] sel_q;

    // Whether the main oscillator counts as stopped when a request is seen.
    always_comb begin
        unique case (state_q)
            ST_SUBRUN:  halt_at_req = osc_halted_i;
            ST_INIT:    halt_at_req = halt_q;
            ST_OSCWAIT: halt_at_req = 1'b1;
            default:    halt_at_req = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUBRUN, ST_MAINRUN: state_d = state_q;
            ST_INIT: begin
                if (dwell_i == DW'(INIT_LEN - 1)) begin
                    state_d = halt_q ? ST_OSCWAIT : ST_OPRST;
                end
            end
            ST_OSCWAIT: begin
                if (tap_hit_i) begin
                    state_d = ST_OPRST;
                end
            end
            ST_OPRST: begin
                if (dwell_i == DW'(RST_LEN - 1)) begin
                    state_d = ST_MAINRUN;
                end
            end
            default: state_d = ST_SUBRUN;
        endcase
        if (wdt_req_i) begin
            state_d = ST_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SUBRUN;
            halt_q  <= 1'b0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wdt_req_i) begin
                halt_q <= halt_at_req;
                sel_q  <= ivl_sel_i;
            end
        end
    end

    assign dwell_clear_o = wdt_req_i || (state_d != state_q);
    assign tb_clear_o    = (state_d == ST_OSCWAIT) && (state_q != ST_OSCWAIT);
    assign sel_o         = sel_q;
    assign state_o       = state_q;

    always_comb begin
        osc_en_o   = 1'b1;
        init_rst_o = 1'b0;
        op_rst_o   = 1'b0;
        unique case (state_q)
            ST_SUBRUN:  osc_en_o = ~osc_halted_i;
            ST_INIT: begin
                osc_en_o   = ~halt_q;
                init_rst_o = 1'b1;
            end
            ST_OSCWAIT: osc_en_o = 1'b1;
            ST_OPRST:   op_rst_o = 1'b1;
            ST_MAINRUN: osc_en_o = 1'b1;
            default:    osc_en_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/osc_stab_seq.sv
module osc_stab_seq
    import osc_stab_pkg::*;
#(
    parameter int unsigned TAP0     = 12,
    parameter int unsigned TAP1     = 14,
    parameter int unsigned TAP2     = 17,
    parameter int unsigned TAP3     = 22,
    parameter int unsigned INIT_LEN = 4,
    parameter int unsigned RST_LEN  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdt_req_i,
    input  logic       osc_halted_i,
    input  logic [1:0] ivl_sel_i,
    output logic       osc_en_o,
    output logic       init_rst_o,
    output logic       op_rst_o,
    output logic [2:0] state_o
);

    localparam int unsigned DW = $clog2(max2(INIT_LEN, RST_LEN) + 1);

    seq_state_e       state;
    logic [SEL_W-1:0] sel_cap;
    logic             tb_clear, dwell_clear, tap_hit;
    logic [DW-1:0]    dwell;

    osc_stab_fsm #(
        .INIT_LEN (INIT_LEN),
        .RST_LEN  (RST_LEN),
        .DW       (DW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdt_req_i     (wdt_req_i),
        .osc_halted_i  (osc_halted_i),
        .ivl_sel_i     (ivl_sel_i),
        .tap_hit_i     (tap_hit),
        .dwell_i       (dwell),
        .state_o       (state),
        .sel_o         (sel_cap),
        .tb_clear_o    (tb_clear),
        .dwell_clear_o (dwell_clear),
        .osc_en_o      (osc_en_o),
        .init_rst_o    (init_rst_o),
        .op_rst_o      (op_rst_o)
    );

    osc_stab_timebase #(
        .TAP0 (TAP0),
        .TAP1 (TAP1),
        .TAP2 (TAP2),
        .TAP3 (TAP3)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (osc_en_o),
        .clear_i (tb_clear),
        .sel_i   (sel_cap),
        .hit_o   (tap_hit)
    );

    osc_stab_dwell #(
        .W (DW)
    ) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (dwell_clear),
        .cnt_o   (dwell)
    );

    assign state_o = state;

endmodule

// File: rtl/osc_stab_seq_chk.sv
module osc_stab_seq_chk
    import osc_stab_pkg::*;
#(
    parameter int unsigned RST_LEN = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_req_i,
    input logic       osc_en_o,
    input logic       init_rst_o,
    input logic       op_rst_o,
    input logic [2:0] state_o
);

    localparam int unsigned RW = $clog2(RST_LEN + 1);

    // Consecutive cycles already spent in OPRST before the current one.
    logic [RW-1:0] rst_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cycles <= '0;
        end else if (state_o == ST_OPRST) begin
            if (rst_cycles != {RW{1'b1}}) begin
                rst_cycles <= rst_cycles + 1'b1;
            end
        end else begin
            rst_cycles <= '0;
        end
    end

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    p_req_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_i |=> (state_o == ST_INIT));

    p_init_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_INIT) |-> (init_rst_o && !op_rst_o));

    p_init_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_INIT && !wdt_req_i) |=>
            (state_o == ST_INIT || state_o == ST_OSCWAIT || state_o == ST_OPRST));

    p_wait_outs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OSCWAIT) |-> (osc_en_o && !init_rst_o && !op_rst_o));

    p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OSCWAIT && !wdt_req_i) |=>
            (state_o == ST_OSCWAIT || state_o == ST_OPRST));

    p_rst_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OPRST) |-> (rst_cycles < RW'(RST_LEN)));

    p_rst_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OPRST && rst_cycles == RW'(RST_LEN - 1) && !wdt_req_i) |=>
            (state_o == ST_MAINRUN));

    p_main_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_MAINRUN && !wdt_req_i) |=> (state_o == ST_MAINRUN));

    p_resets_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_rst_o && op_rst_o));

endmodule

bind osc_stab_seq osc_stab_seq_chk #(
    .RST_LEN (RST_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdt_req_i  (wdt_req_i),
    .osc_en_o   (osc_en_o),
    .init_rst_o (init_rst_o),
    .op_rst_o   (op_rst_o),
    .state_o    (state_o)
);

// File: tb/osc_stab_seq_tb.sv
module osc_stab_seq_tb;

    localparam int T0 = 3;
    localparam int T1 = 4;
    localparam int T2 = 5;
    localparam int T3 = 7;
    localparam int INIT_LEN = 4;
    localparam int RST_LEN  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_req = 1'b0;
    logic       osc_halted = 1'b0;
    logic [1:0] ivl_sel = 2'd0;
    logic       osc_en, init_rst, op_rst;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    osc_stab_seq #(
        .TAP0 (T0), .TAP1 (T1), .TAP2 (T2), .TAP3 (T3),
        .INIT_LEN (INIT_LEN), .RST_LEN (RST_LEN)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdt_req_i    (wdt_req),
        .osc_halted_i (osc_halted),
        .ivl_sel_i    (ivl_sel),
        .osc_en_o     (osc_en),
        .init_rst_o   (init_rst),
        .op_rst_o     (op_rst),
        .state_o      (state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int wait_len(input int sel);
        int t;
        t = (sel == 0) ? T0 : (sel == 1) ? T1 : (sel == 2) ? T2 : T3;
        return (1 << t) + 1;
    endfunction

    task automatic measure(input int code, output int n);
        n = 0;
        while (int'(state) == code && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset;
        rst_n   = 1'b0;
        wdt_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_req;
        wdt_req = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        osc_halted = 1'b1;
        do_reset;
        pulse_req;
        measure(1, n);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 state in reset", int'(state), 0);
        chk("R1 resets low in reset", int'(init_rst | op_rst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after reset", int'(state), 0);
        chk("R1 osc_en halted", int'(osc_en), 0);
        osc_halted = 1'b0;
        @(negedge clk);
        chk("R1 osc_en running", int'(osc_en), 1);
    endtask

    task automatic t_halted(input int sel);
        int n;
        do_reset;
        osc_halted = 1'b1;
        ivl_sel    = 2'(sel);
        @(negedge clk);
        chk("R4 osc off in SUBRUN", int'(osc_en), 0);
        pulse_req;
        chk("R2 enter INIT", int'(state), 1);
        chk("R2 init_rst in INIT", int'(init_rst), 1);
        chk("R4 osc off in INIT", int'(osc_en), 0);
        measure(1, n);
        chk("R2 INIT length", n, INIT_LEN);
        chk("R3 INIT to OSCWAIT", int'(state), 2);
        chk("R4 osc on in wait", int'(osc_en), 1);
        chk("R4 resets low in wait", int'(init_rst | op_rst), 0);
        measure(2, n);
        chk($sformatf("R5 wait length sel %0d", sel), n, wait_len(sel));
        chk("R7 enter OPRST", int'(state), 3);
        chk("R7 op_rst in OPRST", int'(op_rst), 1);
        chk("R7 init_rst low in OPRST", int'(init_rst), 0);
        measure(3, n);
        chk("R7 OPRST length", n, RST_LEN);
        chk("R7 enter MAINRUN", int'(state), 4);
        chk("R7 MAINRUN outputs", int'({osc_en, init_rst, op_rst}), 4);
        repeat (20) @(negedge clk);
        chk("R7 MAINRUN holds", int'(state), 4);
    endtask

    task automatic t_running;
        int n;
        do_reset;
        osc_halted = 1'b0;
        ivl_sel    = 2'd3;
        pulse_req;
        chk("R4 osc on in INIT", int'(osc_en), 1);
        measure(1, n);
        chk("R2 INIT length running", n, INIT_LEN);
        chk("R3 INIT to OPRST", int'(state), 3);
        measure(3, n);
        chk("R7 OPRST length running", n, RST_LEN);
        chk("R7 MAINRUN running", int'(state), 4);
    endtask

    task automatic t_sel_hold;
        int n;
        do_reset;
        osc_halted = 1'b1;
        ivl_sel    = 2'd0;
        pulse_req;
        ivl_sel = 2'd3;
        measure(1, n);
        chk("R6 wait entered", int'(state), 2);
        measure(2, n);
        chk("R6 wait uses captured code", n, wait_len(0));
        measure(3, n);
        chk("R8 in MAINRUN", int'(state), 4);
        pulse_req;
        measure(1, n);
        chk("R8 MAINRUN request skips wait", int'(state), 3);
    endtask

    task automatic t_restart;
        int n;
        do_reset;
        osc_halted = 1'b1;
        ivl_sel    = 2'd1;
        pulse_req;
        measure(1, n);
        repeat (5) @(negedge clk);
        chk("R8 mid wait", int'(state), 2);
        pulse_req;
        chk("R8 wait restart INIT", int'(state), 1);
        measure(1, n);
        chk("R8 wait again", int'(state), 2);
        measure(2, n);
        chk("R8 full wait after restart", n, wait_len(1));
        repeat (6) @(negedge clk);
        chk("R8 mid OPRST", int'(state), 3);
        pulse_req;
        chk("R8 OPRST restart INIT", int'(state), 1);
        measure(1, n);
        chk("R8 OPRST restart skips wait", int'(state), 3);
        measure(3, n);
        chk("R8 OPRST full after restart", n, RST_LEN);
    endtask

    initial begin
        t_reset;
        for (int s = 0; s < 4; s++) begin
            t_halted(s);
        end
        t_running;
        t_sel_hold;
        t_restart;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule